// File: doc/BRIEF.md
# SCSI Command Register Unit

This block is the host-side register file and command decoder of a simple SCSI bus initiator controller. A byte-wide host bus reads and writes a small set of registers. The register index is taken from the bus address after a configurable right shift. Writing the command register starts one of a fixed set of actions:

- no-operation
- FIFO flush
- chip reset
- bus reset
- initiator-complete
- message accept
- set-attention
- three kinds of target selection
- enable-selection

Each action loads its own fixed pattern into the status, interrupt-cause and sequence-step registers. A single level interrupt output follows the interrupt flag in the status register.

The read view and the write view of the register space are separate banks. The host-written transfer count only reaches the readable live count when a command is issued with its DMA bit set. Reading the interrupt-cause register returns the value and then clears it, which also lowers the interrupt line. Selection outcomes come from a per-target "present" input vector, not from real bus signalling. A small byte FIFO accepts host writes. Host reads of the FIFO register return and remove the oldest byte.

Top module: `scsi_cmd_regs`

## Requirements
- R1: The register index is bits [ADDR_SHIFT+3:ADDR_SHIFT] of `addr`, and the address bits below ADDR_SHIFT are ignored. Writes to index 0 and 1 (transfer count low and mid) land in a write-only copy and do not change what index 0 and 1 read back.
- R2: After reset:
  - the status (read index 4), interrupt-cause (5), sequence-step (6), flags (7) and live transfer count (0, 1) registers read 0x00;
  - index 14 reads the identifier 0x04;
  - index 8 (config) reads 0x07;
  - `irq` is low.
- R3: Bit 7 of status is the interrupt flag, and `irq` equals it. Only a write to the command register (index 3) can raise `irq`. Writes to any other index leave `irq` unchanged.
- R4: Reading index 5 returns its present value. At the next clock edge the same read clears the interrupt-cause register, clears status bits 7 and 4 (terminal count), sets the sequence step to 4 and drops `irq`.
- R5: Command 0x01 empties the FIFO and sets interrupt-cause = 0x08 (function complete), sequence = 0 and flags = 0, without raising `irq`.
- R6: Command 0x02 returns every register and the FIFO to the R2 state and drops `irq`.
- R7: Command 0x03 sets interrupt-cause = 0x80. It raises `irq` (status bit 7) only when bit 6 of the last value written to index 8 is 0. Otherwise status and `irq` are unchanged. A write to index 8 also sets what index 8 reads.
- R8: The interrupt-cause commands are as follows:
  - Command 0x12 sets interrupt-cause = 0x20 (disconnect), sequence = 0 and flags = 0.
  - Command 0x11 sets interrupt-cause = 0x08 and ORs the message-in phase 0x07 into status.
  - Command 0x44 clears interrupt-cause.
  - None of the three raises `irq`.
- R9: A recognised command written with bit 7 set copies the last written transfer count low and mid bytes into the live count (read index 0 and 1). Bits [6:0] select the command.
- R10: For selection commands 0x41, 0x42 and 0x43 the target is bits [2:0] of the last write to index 4. If `tgt_present` has a 0 at that target, the command sets interrupt-cause = 0x20 and sequence = 0. It also sets status to 0 and then raises the interrupt, so status reads 0x80 and `irq` goes high.
- R11: When the selected target is present, commands 0x41 and 0x42 set status = 0x90 (terminal count and interrupt), interrupt-cause = 0x18 (bus service and function complete) and sequence = 4. Command 0x43 does the same but with status = 0x92 (adds command phase 0x02). All three raise `irq`.
- R12: The FIFO behaves as follows:
  - Writes to index 2 append a byte to the FIFO and clear status bit 4.
  - Reads of index 2 return and remove bytes in write order.
  - A read of an empty FIFO returns 0x00.
  - A write made while the FIFO holds FIFO_DEPTH-1 bytes is dropped.
- R13: Index 3 reads back the last command byte written. A command code outside the recognised set (0x00 and 0x1A are recognised no-ops) changes nothing else, even with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| addr | input | ADDR_SHIFT+4 | Host byte address; the register index sits above the shift |
| wr_en | input | 1 | Host write strobe for one cycle; wins over `rd_en` |
| rd_en | input | 1 | Host read strobe for one cycle; side effects apply at the clock edge |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the addressed register, valid while `rd_en` is high |
| tgt_present | input | 8 | One bit per target ID, 1 when that target answers selection |
| irq | output | 1 | Level interrupt, high while the status interrupt flag is set |

## Verification
The hardest situations to reach are the ones where a command must leave the interrupt line alone while still loading a cause code. These are a bus reset with the suppress bit set in the config copy, and a flush that follows a raised selection. The stimulus first walks the config register through both values of bit 6 around two bus-reset commands. It then reads status and cause before and after each interrupt-cause read, which exposes both the suppression and the clearing side effects. The FIFO overrun boundary is reached by writing one byte more than the usable depth and then draining it completely, so a dropped or duplicated byte shows up in the read order.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

   localparam int REG_IDX_W   = 4;
   localparam int NUM_TARGETS = 8;
   localparam int TGT_W       = 3;

   // register indices (after the address shift)
   localparam logic [3:0] RI_XFER_LO  = 4'd0;
   localparam logic [3:0] RI_XFER_MID = 4'd1;
   localparam logic [3:0] RI_FIFO     = 4'd2;
   localparam logic [3:0] RI_CMD      = 4'd3;
   localparam logic [3:0] RI_STAT_TGT = 4'd4;
   localparam logic [3:0] RI_INTR     = 4'd5;
   localparam logic [3:0] RI_SEQ      = 4'd6;
   localparam logic [3:0] RI_FLAGS    = 4'd7;
   localparam logic [3:0] RI_CFG1     = 4'd8;
   localparam logic [3:0] RI_XFER_HI  = 4'd14;

   // status bits and phase codes
   localparam logic [7:0] ST_IRQ_FLAG = 8'h80;
   localparam logic [7:0] ST_TERM_CNT = 8'h10;
   localparam logic [7:0] ST_PH_CMD   = 8'h02;
   localparam logic [7:0] ST_PH_MSGIN = 8'h07;

   // interrupt-cause bits
   localparam logic [7:0] IC_BUS_RST  = 8'h80;
   localparam logic [7:0] IC_DISCON   = 8'h20;
   localparam logic [7:0] IC_BUS_SVC  = 8'h10;
   localparam logic [7:0] IC_FN_DONE  = 8'h08;

   localparam logic [7:0] SEQ_IDLE    = 8'h00;
   localparam logic [7:0] SEQ_DONE    = 8'h04;

   localparam logic [7:0] CHIP_ID     = 8'h04;
   localparam logic [7:0] CFG1_INIT   = 8'h07;

   // command codes (bits [6:0] of the command byte)
   localparam logic [6:0] CMD_NOP       = 7'h00;
   localparam logic [6:0] CMD_FLUSH     = 7'h01;
   localparam logic [6:0] CMD_CHIP_RST  = 7'h02;
   localparam logic [6:0] CMD_BUS_RST   = 7'h03;
   localparam logic [6:0] CMD_INIT_DONE = 7'h11;
   localparam logic [6:0] CMD_MSG_ACK   = 7'h12;
   localparam logic [6:0] CMD_SET_ATTN  = 7'h1a;
   localparam logic [6:0] CMD_SEL_PLAIN = 7'h41;
   localparam logic [6:0] CMD_SEL_ATTN  = 7'h42;
   localparam logic [6:0] CMD_SEL_STOP  = 7'h43;
   localparam logic [6:0] CMD_SEL_EN    = 7'h44;

   typedef struct packed {
      logic [7:0] stat;
      logic [7:0] intr;
      logic [7:0] seq;
      logic [7:0] flags;
   } ctl_state_t;

endpackage

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     push,
   input  logic                     pop,
   input  logic [WIDTH-1:0]         din,
   output logic [WIDTH-1:0]         dout,
   output logic [$clog2(DEPTH):0]   count
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH - 1);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("scsi_byte_fifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;
   logic             take;
   logic             give;

   assign take = push && (count != FULL_LVL);
   assign give = pop && (count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (take) wr_ptr <= wr_ptr + 1'b1;
         if (give) rd_ptr <= rd_ptr + 1'b1;
         case ({take, give})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (take && !flush) mem[wr_ptr] <= din;
   end

   assign dout = (count != '0) ? mem[rd_ptr] : '0;

endmodule

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
   import scsi_regs_pkg::*;
(
   input  logic [7:0]  cmd,
   input  ctl_state_t  cur,
   input  logic        rst_rep_off,
   input  logic        tgt_ok,
   output ctl_state_t  nxt,
   output logic        known,
   output logic        raise,
   output logic        do_flush,
   output logic        do_chip_rst
);

   always_comb begin
      nxt         = cur;
      known       = 1'b1;
      raise       = 1'b0;
      do_flush    = 1'b0;
      do_chip_rst = 1'b0;
      case (cmd[6:0])
         CMD_NOP, CMD_SET_ATTN: begin
         end
         CMD_FLUSH: begin
            do_flush  = 1'b1;
            nxt.intr  = IC_FN_DONE;
            nxt.seq   = SEQ_IDLE;
            nxt.flags = 8'h00;
         end
         CMD_CHIP_RST: begin
            do_chip_rst = 1'b1;
         end
         CMD_BUS_RST: begin
            nxt.intr = IC_BUS_RST;
            raise    = !rst_rep_off;
         end
         CMD_INIT_DONE: begin
            nxt.intr = IC_FN_DONE;
            nxt.stat = cur.stat | ST_PH_MSGIN;
         end
         CMD_MSG_ACK: begin
            nxt.intr  = IC_DISCON;
            nxt.seq   = SEQ_IDLE;
            nxt.flags = 8'h00;
         end
         CMD_SEL_PLAIN, CMD_SEL_ATTN, CMD_SEL_STOP: begin
            raise = 1'b1;
            if (!tgt_ok) begin
               nxt.stat = 8'h00;
               nxt.intr = IC_DISCON;
               nxt.seq  = SEQ_IDLE;
            end else begin
               nxt.stat = (cmd[6:0] == CMD_SEL_STOP) ? (ST_TERM_CNT | ST_PH_CMD)
                                                     : ST_TERM_CNT;
               nxt.intr = IC_BUS_SVC | IC_FN_DONE;
               nxt.seq  = SEQ_DONE;
            end
         end
         CMD_SEL_EN: begin
            nxt.intr = 8'h00;
         end
         default: begin
            known = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
   import scsi_regs_pkg::*;
#(
   parameter int ADDR_SHIFT = 2,
   parameter int FIFO_DEPTH = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_SHIFT+REG_IDX_W-1:0] addr,
   input  logic                            wr_en,
   input  logic                            rd_en,
   input  logic [7:0]                      wdata,
   output logic [7:0]                      rdata,
   input  logic [NUM_TARGETS-1:0]          tgt_present,
   output logic                            irq
);

   localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

   generate
      if (ADDR_SHIFT < 0 || ADDR_SHIFT > 8) begin : g_bad_shift
         $error("scsi_cmd_regs: ADDR_SHIFT out of range 0..8");
      end
   endgenerate

   logic [REG_IDX_W-1:0] reg_idx;

   generate
      if (ADDR_SHIFT > 0) begin : g_shifted
         logic unused_low_bits;
         assign reg_idx         = addr[ADDR_SHIFT +: REG_IDX_W];
         assign unused_low_bits = ^addr[ADDR_SHIFT-1:0];
      end else begin : g_direct
         assign reg_idx = addr[REG_IDX_W-1:0];
      end
   endgenerate

   // read-side state
   ctl_state_t st;
   logic [7:0] live_lo;
   logic [7:0] live_mid;
   logic [7:0] cfg1_rd;
   logic       irq_q;

   // write-side copies
   logic [7:0]       wr_lo;
   logic [7:0]       wr_mid;
   logic [7:0]       wr_cmd;
   logic [TGT_W-1:0] wr_tgt;
   logic             wr_rep_off;

   // decoder
   ctl_state_t dec_nxt;
   logic       dec_known;
   logic       dec_raise;
   logic       dec_flush;
   logic       dec_rst;
   logic [7:0] stat_after_cmd;

   logic cmd_wr;
   logic intr_rd;
   logic fifo_push;
   logic fifo_pop;
   logic fifo_flush;
   logic [7:0] fifo_dout;
   logic [CNT_W-1:0] fifo_count;

   assign cmd_wr    = wr_en && (reg_idx == RI_CMD);
   assign intr_rd   = rd_en && !wr_en && (reg_idx == RI_INTR);
   assign fifo_push = wr_en && (reg_idx == RI_FIFO);
   assign fifo_pop  = rd_en && !wr_en && (reg_idx == RI_FIFO);
   assign fifo_flush = cmd_wr && dec_known && (dec_flush || dec_rst);

   scsi_cmd_decode i_decode (
      .cmd         (wdata),
      .cur         (st),
      .rst_rep_off (wr_rep_off),
      .tgt_ok      (tgt_present[wr_tgt]),
      .nxt         (dec_nxt),
      .known       (dec_known),
      .raise       (dec_raise),
      .do_flush    (dec_flush),
      .do_chip_rst (dec_rst)
   );

   assign stat_after_cmd = dec_nxt.stat | (dec_raise ? ST_IRQ_FLAG : 8'h00);

   scsi_byte_fifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (8)
   ) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (fifo_flush),
      .push  (fifo_push),
      .pop   (fifo_pop),
      .din   (wdata),
      .dout  (fifo_dout),
      .count (fifo_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || (cmd_wr && dec_known && dec_rst)) begin
         st         <= '0;
         live_lo    <= 8'h00;
         live_mid   <= 8'h00;
         cfg1_rd    <= CFG1_INIT;
         irq_q      <= 1'b0;
         wr_lo      <= 8'h00;
         wr_mid     <= 8'h00;
         wr_cmd     <= 8'h00;
         wr_tgt     <= '0;
         wr_rep_off <= 1'b0;
      end else if (wr_en) begin
         case (reg_idx)
            RI_XFER_LO:  wr_lo  <= wdata;
            RI_XFER_MID: wr_mid <= wdata;
            RI_FIFO:     st.stat <= st.stat & ~ST_TERM_CNT;
            RI_CMD: begin
               wr_cmd <= wdata;
               if (dec_known) begin
                  st.stat  <= stat_after_cmd;
                  st.intr  <= dec_nxt.intr;
                  st.seq   <= dec_nxt.seq;
                  st.flags <= dec_nxt.flags;
                  irq_q    <= stat_after_cmd[7];
                  if (wdata[7]) begin
                     live_lo  <= wr_lo;
                     live_mid <= wr_mid;
                  end
               end
            end
            RI_STAT_TGT: wr_tgt <= wdata[TGT_W-1:0];
            RI_CFG1: begin
               cfg1_rd    <= wdata;
               wr_rep_off <= wdata[6];
            end
            default: begin
            end
         endcase
      end else if (intr_rd) begin
         st.intr <= 8'h00;
         st.stat <= st.stat & ~(ST_IRQ_FLAG | ST_TERM_CNT);
         st.seq  <= SEQ_DONE;
         irq_q   <= 1'b0;
      end
   end

   always_comb begin
      case (reg_idx)
         RI_XFER_LO:  rdata = live_lo;
         RI_XFER_MID: rdata = live_mid;
         RI_FIFO:     rdata = fifo_dout;
         RI_CMD:      rdata = wr_cmd;
         RI_STAT_TGT: rdata = st.stat;
         RI_INTR:     rdata = st.intr;
         RI_SEQ:      rdata = st.seq;
         RI_FLAGS:    rdata = st.flags;
         RI_CFG1:     rdata = cfg1_rd;
         RI_XFER_HI:  rdata = CHIP_ID;
         default:     rdata = 8'h00;
      endcase
   end

   assign irq = irq_q;

endmodule

// File: rtl/scsi_cmd_regs_chk.sv
module scsi_cmd_regs_chk
   import scsi_regs_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [3:0]       reg_idx,
   input logic [7:0]       wdata,
   input logic             irq,
   input logic [CNT_W-1:0] fifo_cnt
);

   // R3
   irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wr_en && reg_idx == RI_CMD));

   // R3
   irq_quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_idx != RI_CMD) |=> $stable(irq));

   // R4
   irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(rd_en && reg_idx == RI_INTR) || $past(wr_en && reg_idx == RI_CMD)));

   // R4
   intr_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && reg_idx == RI_INTR) |=> !irq);

   // R6
   chip_rst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_idx == RI_CMD && wdata[6:0] == CMD_CHIP_RST) |=> !irq);

   // R12
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(FIFO_DEPTH - 1));

endmodule

bind scsi_cmd_regs scsi_cmd_regs_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .CNT_W      ($clog2(FIFO_DEPTH) + 1)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .reg_idx  (reg_idx),
   .wdata    (wdata),
   .irq      (irq),
   .fifo_cnt (fifo_count)
);

// File: tb/test_scsi_cmd_regs.sv
`timescale 1ns/1ps
module test_scsi_cmd_regs;

   localparam int SH    = 2;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [SH+3:0] addr = '0;
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rdata;
   logic [7:0]    tgt_present = 8'h01;
   logic          irq;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
      string      what;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   scsi_cmd_regs #(.ADDR_SHIFT(SH), .FIFO_DEPTH(DEPTH)) i_scsi_cmd_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .wdata       (wdata),
      .rdata       (rdata),
      .tgt_present (tgt_present),
      .irq         (irq)
   );

   task automatic wr(input logic [3:0] idx, input logic [7:0] d);
      @(negedge clk);
      addr  = {idx, {SH{1'b0}}};
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: pushes the expected byte, monitor compares it
   task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string tag,
                     input string what);
      item_t it;
      @(negedge clk);
      addr  = {idx, SH'(idx)};
      rd_en = 1'b1;
      it.exp  = exp;
      it.tag  = tag;
      it.what = what;
      sb.push_back(it);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      #1;
      checks++;
      if (irq !== exp) begin
         fails++;
         $display("FAIL %s: irq got %0b expected %0b", tag, irq, exp);
      end
   endtask

   // monitor
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #1;
         if (rd_en && sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (rdata !== it.exp) begin
               fails++;
               $display("FAIL %s: %s got %02h expected %02h", it.tag, it.what, rdata, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      chk_irq(1'b0, "R2");
      rd(4'd6, 8'h00, "R2", "seq after reset");
      rd(4'd7, 8'h00, "R2", "flags after reset");
      rd(4'd4, 8'h00, "R2", "status after reset");
      rd(4'd0, 8'h00, "R2", "live count low after reset");
      rd(4'd8, 8'h07, "R2", "config after reset");
      rd(4'd14, 8'h04, "R2", "identifier");
      rd(4'd5, 8'h00, "R2", "cause after reset");

      // R1 separate banks, R9 reload on DMA command
      wr(4'd0, 8'h34);
      wr(4'd1, 8'h12);
      rd(4'd0, 8'h00, "R1", "live low before reload");
      rd(4'd1, 8'h00, "R1", "live mid before reload");
      wr(4'd3, 8'h80);
      rd(4'd0, 8'h34, "R9", "live low after reload");
      rd(4'd1, 8'h12, "R9", "live mid after reload");
      rd(4'd3, 8'h80, "R13", "command readback");

      // R12 FIFO order and empty read
      wr(4'd2, 8'hA1);
      wr(4'd2, 8'hA2);
      wr(4'd2, 8'hA3);
      rd(4'd2, 8'hA1, "R12", "fifo byte 0");
      rd(4'd2, 8'hA2, "R12", "fifo byte 1");
      rd(4'd2, 8'hA3, "R12", "fifo byte 2");
      rd(4'd2, 8'h00, "R12", "fifo empty");

      // R12 overrun: one write more than capacity
      for (int i = 0; i < DEPTH; i++) wr(4'd2, 8'(8'h40 + i));
      for (int i = 0; i < DEPTH - 1; i++) rd(4'd2, 8'(8'h40 + i), "R12", "fifo drain");
      rd(4'd2, 8'h00, "R12", "overrun byte dropped");

      // R5 flush
      wr(4'd2, 8'h11);
      wr(4'd2, 8'h22);
      wr(4'd3, 8'h01);
      chk_irq(1'b0, "R5");
      rd(4'd2, 8'h00, "R5", "fifo after flush");
      rd(4'd6, 8'h00, "R5", "seq after flush");
      rd(4'd7, 8'h00, "R5", "flags after flush");
      rd(4'd5, 8'h08, "R5", "cause after flush");
      rd(4'd6, 8'h04, "R4", "seq after cause read");
      rd(4'd5, 8'h00, "R4", "cause cleared by read");

      // R10 absent target
      wr(4'd4, 8'h03);
      wr(4'd3, 8'h42);
      chk_irq(1'b1, "R10");
      rd(4'd4, 8'h80, "R10", "status absent");
      rd(4'd6, 8'h00, "R10", "seq absent");
      rd(4'd5, 8'h20, "R10", "cause absent");
      chk_irq(1'b0, "R4");
      rd(4'd4, 8'h00, "R4", "status after cause read");

      // R11 present target, stop variant
      wr(4'd4, 8'h00);
      wr(4'd3, 8'h43);
      chk_irq(1'b1, "R11");
      rd(4'd4, 8'h92, "R11", "status stop select");
      rd(4'd6, 8'h04, "R11", "seq stop select");
      wr(4'd2, 8'h5A);
      rd(4'd4, 8'h82, "R12", "fifo write clears terminal count");
      chk_irq(1'b1, "R3");
      rd(4'd5, 8'h18, "R11", "cause stop select");
      rd(4'd4, 8'h02, "R4", "status keeps phase after read");
      chk_irq(1'b0, "R4");
      wr(4'd3, 8'h41);
      chk_irq(1'b1, "R11");
      rd(4'd4, 8'h90, "R11", "status plain select");
      rd(4'd5, 8'h18, "R11", "cause plain select");
      wr(4'd3, 8'h01);
      rd(4'd5, 8'h08, "R5", "cause flush after select");
      rd(4'd2, 8'h00, "R5", "fifo emptied");

      // R7 bus reset with and without suppression
      wr(4'd8, 8'h40);
      rd(4'd8, 8'h40, "R7", "config written");
      wr(4'd3, 8'h03);
      chk_irq(1'b0, "R7");
      rd(4'd4, 8'h00, "R7", "status suppressed bus reset");
      rd(4'd5, 8'h80, "R7", "cause suppressed bus reset");
      wr(4'd8, 8'h00);
      wr(4'd3, 8'h03);
      chk_irq(1'b1, "R7");
      rd(4'd4, 8'h80, "R7", "status bus reset");
      rd(4'd5, 8'h80, "R7", "cause bus reset");
      chk_irq(1'b0, "R7");

      // R8 cause-only commands
      wr(4'd3, 8'h11);
      rd(4'd4, 8'h07, "R8", "status message-in");
      rd(4'd5, 8'h08, "R8", "cause initiator complete");
      wr(4'd3, 8'h12);
      rd(4'd6, 8'h00, "R8", "seq message accept");
      rd(4'd7, 8'h00, "R8", "flags message accept");
      rd(4'd5, 8'h20, "R8", "cause message accept");
      wr(4'd3, 8'h12);
      wr(4'd3, 8'h44);
      rd(4'd5, 8'h00, "R8", "cause after enable-select");
      chk_irq(1'b0, "R8");

      // R13 unknown command
      wr(4'd3, 8'h12);
      wr(4'd0, 8'h77);
      wr(4'd3, 8'hD5);
      rd(4'd3, 8'hD5, "R13", "unknown command readback");
      rd(4'd0, 8'h34, "R13", "live count untouched");
      rd(4'd6, 8'h00, "R13", "seq untouched");
      rd(4'd5, 8'h20, "R13", "cause untouched");
      chk_irq(1'b0, "R13");

      // R6 chip reset
      wr(4'd4, 8'h03);
      wr(4'd3, 8'h42);
      chk_irq(1'b1, "R10");
      wr(4'd8, 8'h40);
      wr(4'd2, 8'h99);
      wr(4'd3, 8'h02);
      chk_irq(1'b0, "R6");
      rd(4'd8, 8'h07, "R6", "config after chip reset");
      rd(4'd14, 8'h04, "R6", "identifier after chip reset");
      rd(4'd0, 8'h00, "R6", "live low after chip reset");
      rd(4'd2, 8'h00, "R6", "fifo after chip reset");
      rd(4'd4, 8'h00, "R6", "status after chip reset");
      rd(4'd6, 8'h00, "R6", "seq after chip reset");
      rd(4'd5, 8'h00, "R6", "cause after chip reset");

      // R9 reload on a real command
      wr(4'd0, 8'h55);
      wr(4'd1, 8'h66);
      wr(4'd3, 8'h81);
      rd(4'd0, 8'h55, "R9", "live low flush+dma");
      rd(4'd1, 8'h66, "R9", "live mid flush+dma");
      rd(4'd5, 8'h08, "R9", "flush still decoded with dma bit");

      repeat (4) @(negedge clk);
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: %0d reads not compared", sb.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule